// File: doc/BRIEF.md
# Half-Rate Three-Tap Window Adder

This block produces the running three-sample window sum y[n] = b[n] + b[n+1] + b[n+2] over a stream of unsigned 8-bit samples. It is meant for a memory port that delivers only two samples per clock. Three operands cannot all arrive in the same cycle. The block therefore takes each window over two cycles and keeps the early samples in delay registers until the last operand arrives. The pipeline alternates between slots that carry a real result and junk slots. This gives one valid sum every second cycle, about half the rate of a port wide enough for three samples.

The block runs freely from the release of a synchronous reset. Counting the first cycle with reset low as cycle 1, odd cycles are pair slots and even cycles are single slots. For window n, the feeding logic presents b[n] on the low lane and b[n+1] on the high lane in cycle 2n+1. In cycle 2n+2 it presents b[n+2] on the low lane, and the high lane is not used. An output flag marks the pair slots, so the address logic outside the block can stay in step. The sum is 10 bits wide, so it cannot overflow.

Top module: `win3_halfrate_adder`

## Requirements
- R1: While reset is high, and in the cycle after it is sampled high, sumValid is 0 and sumOut is 0. Reset clears every pipeline, delay and valid register.
- R2: Lane schedule. In cycle 2n+1 after reset release, laneLo carries b[n] and laneHi carries b[n+1]. In cycle 2n+2, laneLo carries b[n+2].
- R3: In even (single) slots, the value on laneHi has no effect on any output.
- R4: A valid sumOut equals b[n]+b[n+1]+b[n+2] as a 10-bit unsigned value, with no overflow up to 765 when all three samples are 255.
- R5: The sum for window n is valid in cycle 2n+5. The first valid result appears in cycle 5.
- R6: After the first result, sumValid is high in every odd cycle and low in every even (junk) cycle.
- R7: Asserting reset in the middle of a stream discards the results in flight and restarts the phase. The first result after release again comes in cycle 5.
- R8: sumValid is low in cycles 1 to 4 after reset release.
- R9: pairSlot is 1 in odd cycles and 0 in even cycles, starting at 1 in cycle 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| laneLo | input | 8 | First sample of the cycle (b[n] in a pair slot, b[n+2] in a single slot) |
| laneHi | input | 8 | Second sample, b[n+1], used in pair slots only |
| pairSlot | output | 1 | High when the current cycle expects a sample pair |
| sumOut | output | 10 | Window sum, meaningful when sumValid is high |
| sumValid | output | 1 | High in cycles that carry a real result |

## Verification
The hardest case to reach from the ports is a reset that arrives while several windows are still inside the pipeline. That reset must discard them and restart the phase, so the first result after release comes in cycle 5 again. The bench cuts streams off at both odd and even cycles, with windows at several stages of the pipeline, and then starts a fresh stream with a different sample pattern. A wrong result that leaked through, or a phase that was not reset, would then show up as a wrong sum or a misplaced valid. The bench also drives the unused high lane in single slots with all-zero, all-one and varying junk to show that it has no effect.

// File: rtl/win3_pkg.sv
package win3_pkg;
  // Per-cycle strobes the control issues to the datapath.
  typedef struct packed {
    logic capPair;   // latch laneLo/laneHi as b[n], b[n+1]
    logic capThird;  // latch laneLo as b[n+2] into the delay register
    logic addPair;   // first adder: b[n] + b[n+1]
    logic addThird;  // second adder: partial + b[n+2]
    logic emit;      // load the output register
  } win3_strobe_t;
endpackage

// File: rtl/win3_ctrl.sv
module win3_ctrl
  import win3_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  output win3_strobe_t strobe,
  output logic         pairSlot
);
  logic pairPhase;

  always_ff @(posedge clk) begin
    if (rst) pairPhase <= 1'b1;
    else     pairPhase <= ~pairPhase;
  end

  always_comb begin
    strobe.capPair  = pairPhase  & ~rst;
    strobe.addThird = pairPhase  & ~rst;
    strobe.capThird = ~pairPhase & ~rst;
    strobe.addPair  = ~pairPhase & ~rst;
    strobe.emit     = ~pairPhase & ~rst;
  end

  assign pairSlot = pairPhase;
endmodule

// File: rtl/win3_datapath.sv
module win3_datapath
  import win3_pkg::*;
#(
  parameter int SAMPLE_W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  win3_strobe_t          strobe,
  input  logic [SAMPLE_W-1:0]   laneLo,
  input  logic [SAMPLE_W-1:0]   laneHi,
  output logic [SAMPLE_W+1:0]   sumOut,
  output logic                  sumValid
);
  localparam int PART_W = SAMPLE_W + 1;
  localparam int SUM_W  = SAMPLE_W + 2;

  logic [SAMPLE_W-1:0] pairLo, pairHi, thirdHold;
  logic [PART_W-1:0]   partial;
  logic [SUM_W-1:0]    total, outReg;
  logic                vPair, vPart, vTotal, vOut;

  always_ff @(posedge clk) begin
    if (rst) begin
      pairLo    <= '0;
      pairHi    <= '0;
      thirdHold <= '0;
      partial   <= '0;
      total     <= '0;
      outReg    <= '0;
      vPair     <= 1'b0;
      vPart     <= 1'b0;
      vTotal    <= 1'b0;
      vOut      <= 1'b0;
    end else begin
      if (strobe.capPair) begin
        pairLo <= laneLo;
        pairHi <= laneHi;
        vPair  <= 1'b1;
      end
      if (strobe.capThird) begin
        thirdHold <= laneLo;
      end
      if (strobe.addPair) begin
        partial <= PART_W'(pairLo) + PART_W'(pairHi);
        vPart   <= vPair;
      end
      if (strobe.addThird) begin
        total  <= SUM_W'(partial) + SUM_W'(thirdHold);
        vTotal <= vPart;
      end
      if (strobe.emit) begin
        outReg <= total;
      end
      vOut <= strobe.emit & vTotal;
    end
  end

  assign sumOut   = outReg;
  assign sumValid = vOut;
endmodule

// File: rtl/win3_halfrate_adder.sv
module win3_halfrate_adder
  import win3_pkg::*;
#(
  parameter int SAMPLE_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [SAMPLE_W-1:0] laneLo,
  input  logic [SAMPLE_W-1:0] laneHi,
  output logic                pairSlot,
  output logic [SAMPLE_W+1:0] sumOut,
  output logic                sumValid
);
  win3_strobe_t strobe;

  win3_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .pairSlot (pairSlot)
  );

  win3_datapath #(.SAMPLE_W(SAMPLE_W)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .laneLo   (laneLo),
    .laneHi   (laneHi),
    .sumOut   (sumOut),
    .sumValid (sumValid)
  );
endmodule

// File: rtl/win3_halfrate_chk.sv
module win3_halfrate_chk #(
  parameter int SAMPLE_W = 8
) (
  input logic                clk,
  input logic                rst,
  input logic [SAMPLE_W-1:0] laneLo,
  input logic [SAMPLE_W-1:0] laneHi,
  input logic                pairSlot,
  input logic [SAMPLE_W+1:0] sumOut,
  input logic                sumValid
);
  localparam int SUM_W = SAMPLE_W + 2;
  localparam logic [SUM_W-1:0] SUM_MAX = SUM_W'(3 * ((1 << SAMPLE_W) - 1));

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!sumValid && sumOut == '0));

  // R6
  junk_after_valid_chk: assert property (@(posedge clk) disable iff (rst)
    sumValid |=> !sumValid);

  // R6
  valid_cadence_chk: assert property (@(posedge clk) disable iff (rst)
    sumValid |=> ##1 sumValid);

  // R5
  valid_in_pair_slot_chk: assert property (@(posedge clk) disable iff (rst)
    sumValid |-> pairSlot);

  // R9
  phase_toggle_chk: assert property (@(posedge clk) disable iff (rst)
    pairSlot |=> !pairSlot);

  // R9
  phase_return_chk: assert property (@(posedge clk) disable iff (rst)
    !pairSlot |=> pairSlot);

  // R4
  sum_range_chk: assert property (@(posedge clk) disable iff (rst)
    sumValid |-> (sumOut <= SUM_MAX));

  // R4
  sum_value_chk: assert property (@(posedge clk) disable iff (rst)
    sumValid |-> (sumOut == SUM_W'($past(laneLo, 4)) + SUM_W'($past(laneHi, 4))
                            + SUM_W'($past(laneLo, 3))));
endmodule

bind win3_halfrate_adder win3_halfrate_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .laneLo   (laneLo),
  .laneHi   (laneHi),
  .pairSlot (pairSlot),
  .sumOut   (sumOut),
  .sumValid (sumValid)
);

// File: tb/win3_halfrate_adder_bench.sv
`timescale 1ns/1ps
module win3_halfrate_adder_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] laneLo = '0;
  logic [7:0] laneHi = '0;
  logic       pairSlot;
  logic [9:0] sumOut;
  logic       sumValid;

  int passCnt = 0;
  int failCnt = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  win3_halfrate_adder u_win3_halfrate_adder (
    .clk(clk), .rst(rst), .laneLo(laneLo), .laneHi(laneHi),
    .pairSlot(pairSlot), .sumOut(sumOut), .sumValid(sumValid)
  );

  task automatic check(input bit ok, input string req, input int cyc,
                       input int act, input int exp);
    if (ok) passCnt++;
    else begin
      failCnt++;
      $display("FAIL %s cycle %0d: got %0d expected %0d", req, cyc, act, exp);
    end
  endtask

  function automatic int sampleAt(input int pat, input int k);
    case (pat)
      0: return (k * 37 + 11) & 255;
      1: return 255;
      2: return 0;
      3: return (k * k * 7 + (k >> 2)) & 255;
      default: return (k & 1) ? 255 : (k & 254);
    endcase
  endfunction

  function automatic int junkAt(input int mode, input int c);
    case (mode)
      0: return 0;
      1: return 255;
      default: return (c * 91 + 5) & 255;
    endcase
  endfunction

  // R1: hold reset and check cleared outputs
  task automatic doReset(input int cycles);
    @(negedge clk);
    rst = 1'b1;
    laneLo = 8'hFF;
    laneHi = 8'hFF;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      check(sumValid == 1'b0, "R1 valid", i, sumValid, 0);
      check(sumOut == '0, "R1 sum", i, sumOut, 0);
    end
  endtask

  // Runs cycles 1..nCyc after release; check outputs, then drive inputs.
  task automatic runStream(input int pat, input int junkMode, input int nCyc);
    for (int c = 1; c <= nCyc; c++) begin
      if (c > 1) @(negedge clk);
      rst = 1'b0;
      check(pairSlot == c[0], "R9 pairSlot", c, pairSlot, c[0]);
      if (c < 5) begin
        check(sumValid == 1'b0, "R8 early valid", c, sumValid, 0);
        if (c == 1) check(sumOut == '0, "R1 sum after release", c, sumOut, 0);
      end else if (c[0] == 1'b0) begin
        check(sumValid == 1'b0, "R6 junk slot", c, sumValid, 0);
      end else begin
        int n = (c - 5) / 2;
        int exp = sampleAt(pat, n) + sampleAt(pat, n + 1) + sampleAt(pat, n + 2);
        check(sumValid == 1'b1, (c == 5) ? "R5 first valid" : "R6 valid slot",
              c, sumValid, 1);
        check(int'(sumOut) == exp, (junkMode == 2) ? "R3 sum" : "R4 sum",
              c, sumOut, exp);
      end
      // R2 lane schedule
      if (c[0]) begin
        laneLo = 8'(sampleAt(pat, (c - 1) / 2));
        laneHi = 8'(sampleAt(pat, (c - 1) / 2 + 1));
      end else begin
        laneLo = 8'(sampleAt(pat, (c - 2) / 2 + 2));
        laneHi = 8'(junkAt(junkMode, c));
      end
    end
  endtask

  initial begin
    doReset(3);
    runStream(0, 2, 301);
    doReset(2);             // R7: cut mid-stream on odd cycle
    runStream(1, 0, 40);    // R4 max sum 765
    doReset(1);             // R7: cut on even cycle
    runStream(2, 1, 30);    // R3 junk high lane = 255, zero data
    doReset(2);
    runStream(3, 2, 400);
    doReset(3);
    runStream(4, 1, 77);
    doReset(1);             // R7: restart with results in flight
    runStream(0, 0, 12);
    done = 1'b1;
    $display("%0d/%0d checks passed", passCnt, passCnt + failCnt);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failCnt++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", passCnt, passCnt + failCnt);
      $finish;
    end
  end
endmodule